// File: doc/BRIEF.md
# Dual-Issue Pairing and Interlock Controller

This block sits at the issue stage of an in-order pipeline that can start two instructions per clock. Each cycle it looks at two candidates, the older in slot A and the younger in slot B, and decides how many of them issue: none, only A, or both. Each candidate brings an operation class, a rounding-mode flag used by float operations, a length in instruction words, a destination register with a write flag, and two source registers.

A scoreboard keeps, for every register, how many cycles remain before a consumer of each kind may read it. The wait depends on both ends of the dependency. Integer and load results reach non-float consumers early through forwarding, but float consumers see the full latency. Float results reach stores early. The float latency also depends on the rounding mode. The block also tracks the single integer execute unit, which multi-word integer forms hold for several cycles, and the single float unit. It enforces the rule that branches, flow instructions and calls issue alone, with calls closing both slots for a further window.

The issue decision is combinational from the candidates and registered state. Per-candidate stall flags and reason codes tell the front end why an instruction waited.

Top module: `dual_issue_ctrl`

## Requirements
- R1: `issue_cnt` equals the number of candidates that issue (0, 1 or 2), and a candidate issues exactly when it is valid and its stall flag is low. Either slot accepts any class. Class codes: 0 integer, 1 load, 2 store, 3 float, 4 branch, 5 flow, 6 call, 7 reserved (behaves as integer).
- R2: Issue is in order. Slot B issues only if slot A is valid and issues in the same cycle. A valid B that is held for this reason reports reason code 4 (order).
- R3: Branch (4), flow (5) and call (6) instructions issue alone. When either candidate has one of these classes and A issues, B stalls with reason code 3 (slot).
- R4: After a call issues in cycle t, no instruction issues in cycles t+1 to t+7, and a valid A reports reason 3 in those cycles.
- R5: Integer, load, store and reserved classes need the one integer unit. Two of them never issue in the same cycle. An integer instruction of length field 2 holds the unit for 2 cycles, and one with a length field of 3 or more holds it for 4 cycles. Any other use holds it for 1 cycle. A candidate blocked by the unit reports reason code 2.
- R6: Two float instructions never issue in the same cycle (reason 2 on B). A float may pair with a non-float, non-solo instruction.
- R7: An integer instruction of length field 0 or 1 that writes a register issued in cycle t: a non-float consumer of that register may issue at t+1 and a float consumer at t+2. With length field 2 every consumer waits until t+2. With 3 or more every consumer waits until t+4. A consumer that must wait reports reason code 1 (data).
- R8: A load's result may be used by non-float consumers from t+2 and by float consumers from t+3.
- R9: A float result with `near`=0 is usable by stores from t+2 and by all other consumers from t+3. With `near`=1 these become t+4 and t+5.
- R10: B stalls with reason 1 when A issues in the same cycle and writes a register that B reads.
- R11: After reset every register may be read at once, including register 0, and the unit and slot blocks are clear. With no valid candidate, `issue_cnt` is 0 and both stall flags and reason codes are 0.
- R12: The destination write flag has effect only for classes 0, 1, 3 and 7. Reason codes are 0 when the candidate does not stall. For A the priority is slot, then data, then unit. For B it is order, then slot, then data, then unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Slot A candidate valid |
| a_op | input | 3 | Slot A operation class |
| a_near | input | 1 | Slot A round-to-nearest flag (float only) |
| a_len | input | 3 | Slot A length in instruction words |
| a_we | input | 1 | Slot A writes its destination |
| a_dst | input | 6 | Slot A destination register |
| a_src0 | input | 6 | Slot A first source register |
| a_src1 | input | 6 | Slot A second source register |
| b_vld | input | 1 | Slot B candidate valid |
| b_op | input | 3 | Slot B operation class |
| b_near | input | 1 | Slot B round-to-nearest flag |
| b_len | input | 3 | Slot B length in instruction words |
| b_we | input | 1 | Slot B writes its destination |
| b_dst | input | 6 | Slot B destination register |
| b_src0 | input | 6 | Slot B first source register |
| b_src1 | input | 6 | Slot B second source register |
| issue_cnt | output | 2 | Number of instructions issuing this cycle |
| a_stall | output | 1 | Slot A valid but held |
| b_stall | output | 1 | Slot B valid but held |
| a_why | output | 3 | Slot A stall reason (0 none, 1 data, 2 unit, 3 slot) |
| b_why | output | 3 | Slot B stall reason (0 none, 1 data, 2 unit, 3 slot, 4 order) |

## Verification
The bench targets the places where readiness depends on the consumer as well as the producer. A float consumer that follows an integer or load result must wait the full latency. A store that follows a float result must be let through early. A design that forwarded to every consumer would issue the float one cycle too soon, and one that ignored the store shortcut would hold the store too long. It also goes after the multi-cycle structural windows: the eight-cycle call lockout and the 2- and 4-cycle integer-unit holds. An off-by-one counter there lets an instruction through on the edge cycle. The other targets are the same-cycle dependency from A to B, the in-order kill of B when A waits, and the reason priorities, where a wrong order shows up as a wrong code while the stall itself is still correct.

// File: rtl/dic_pkg.sv
package dic_pkg;

    typedef enum logic [2:0] {
        OP_INT    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_FLOAT  = 3'd3,
        OP_BRANCH = 3'd4,
        OP_FLOW   = 3'd5,
        OP_CALL   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        WHY_NONE  = 3'd0,
        WHY_DATA  = 3'd1,
        WHY_UNIT  = 3'd2,
        WHY_SLOT  = 3'd3,
        WHY_ORDER = 3'd4
    } why_e;

    // consumer category used to pick the relevant wait counter
    typedef enum logic [1:0] {
        CAT_FLT = 2'd0,
        CAT_ST  = 2'd1,
        CAT_OTH = 2'd2
    } cat_e;

    localparam int WW = 3;

    // remaining wait (latency minus one) seen by each consumer category
    typedef struct packed {
        logic [WW-1:0] flt;
        logic [WW-1:0] st;
        logic [WW-1:0] oth;
    } wait_t;

    function automatic logic uses_int(op_e op);
        return (op == OP_INT) || (op == OP_LOAD) || (op == OP_STORE) || (op == OP_RSVD);
    endfunction

    function automatic logic is_solo(op_e op);
        return (op == OP_BRANCH) || (op == OP_FLOW) || (op == OP_CALL);
    endfunction

    function automatic logic writes_reg(op_e op);
        return (op == OP_INT) || (op == OP_LOAD) || (op == OP_FLOAT) || (op == OP_RSVD);
    endfunction

    function automatic cat_e cat_of(op_e op);
        if (op == OP_FLOAT) return CAT_FLT;
        if (op == OP_STORE) return CAT_ST;
        return CAT_OTH;
    endfunction

    function automatic logic is_long(logic [2:0] len);
        return len >= 3'd3;
    endfunction

    // cycles the integer unit stays taken, minus one
    function automatic logic [2:0] hold_m1(op_e op, logic [2:0] len);
        if ((op == OP_INT) || (op == OP_RSVD)) begin
            if (is_long(len)) return 3'd3;
            if (len == 3'd2)  return 3'd1;
        end
        return 3'd0;
    endfunction

    function automatic wait_t wait_of(op_e op, logic near, logic [2:0] len);
        wait_t w;
        w = '0;
        case (op)
            OP_INT, OP_RSVD: begin
                if (is_long(len))     w = '{flt: 3'd3, st: 3'd3, oth: 3'd3};
                else if (len == 3'd2) w = '{flt: 3'd1, st: 3'd1, oth: 3'd1};
                else                  w = '{flt: 3'd1, st: 3'd0, oth: 3'd0};
            end
            OP_LOAD:  w = '{flt: 3'd2, st: 3'd1, oth: 3'd1};
            OP_FLOAT: w = near ? '{flt: 3'd4, st: 3'd3, oth: 3'd4}
                               : '{flt: 3'd2, st: 3'd1, oth: 3'd2};
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dic_scoreboard.sv
module dic_scoreboard
    import dic_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NRD  = 4,
    parameter int NWR  = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd_reg  [NRD],
    input  cat_e          rd_cat  [NRD],
    output logic          rd_ok   [NRD],
    input  logic          wr_en   [NWR],
    input  logic [RW-1:0] wr_reg  [NWR],
    input  wait_t         wr_wait [NWR]
);

    wait_t cnt_q [NREG];
    wait_t cnt_d [NREG];

    function automatic logic [WW-1:0] dec(logic [WW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            cnt_d[r].flt = dec(cnt_q[r].flt);
            cnt_d[r].st  = dec(cnt_q[r].st);
            cnt_d[r].oth = dec(cnt_q[r].oth);
            // later write port is the younger instruction and wins
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w] && (wr_reg[w] == RW'(r))) cnt_d[r] = wr_wait[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) cnt_q[r] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        wait_t sel;
        assign sel = cnt_q[rd_reg[p]];
        assign rd_ok[p] = (rd_cat[p] == CAT_FLT) ? (sel.flt == '0) :
                          (rd_cat[p] == CAT_ST)  ? (sel.st  == '0) :
                                                   (sel.oth == '0);
    end

endmodule

// File: rtl/dic_pair_rules.sv
module dic_pair_rules
    import dic_pkg::*;
#(
    parameter int RW = 6
) (
    input  op_e           a_op,
    input  op_e           b_op,
    input  logic          a_wr,
    input  logic [RW-1:0] a_dst,
    input  logic [RW-1:0] b_src0,
    input  logic [RW-1:0] b_src1,
    output logic          solo,
    output logic          unit_clash,
    output logic          raw
);

    assign solo       = is_solo(a_op) || is_solo(b_op);
    assign unit_clash = (uses_int(a_op) && uses_int(b_op)) ||
                        ((a_op == OP_FLOAT) && (b_op == OP_FLOAT));
    assign raw        = a_wr && ((b_src0 == a_dst) || (b_src1 == a_dst));

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
    import dic_pkg::*;
#(
    parameter int NREG     = 64,
    parameter int CALL_CYC = 8,
    localparam int RW      = $clog2(NREG),
    localparam int LKW     = $clog2(CALL_CYC) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_vld,
    input  logic [2:0]    a_op,
    input  logic          a_near,
    input  logic [2:0]    a_len,
    input  logic          a_we,
    input  logic [RW-1:0] a_dst,
    input  logic [RW-1:0] a_src0,
    input  logic [RW-1:0] a_src1,
    input  logic          b_vld,
    input  logic [2:0]    b_op,
    input  logic          b_near,
    input  logic [2:0]    b_len,
    input  logic          b_we,
    input  logic [RW-1:0] b_dst,
    input  logic [RW-1:0] b_src0,
    input  logic [RW-1:0] b_src1,
    output logic [1:0]    issue_cnt,
    output logic          a_stall,
    output logic          b_stall,
    output logic [2:0]    a_why,
    output logic [2:0]    b_why
);

    typedef struct packed {
        logic [LKW-1:0] lock;
        logic [2:0]     ibusy;
    } st_t;

    st_t  st_q, st_d;
    op_e  opa, opb;
    why_e why_a, why_b;
    logic go_a, go_b;
    logic wr_a, wr_b;
    logic solo, unit_clash, raw;

    logic [RW-1:0] rd_reg  [4];
    cat_e          rd_cat  [4];
    logic          rd_ok   [4];
    logic          wr_en   [2];
    logic [RW-1:0] wr_reg  [2];
    wait_t         wr_wait [2];

    assign opa = op_e'(a_op);
    assign opb = op_e'(b_op);

    assign rd_reg[0] = a_src0;
    assign rd_reg[1] = a_src1;
    assign rd_reg[2] = b_src0;
    assign rd_reg[3] = b_src1;
    assign rd_cat[0] = cat_of(opa);
    assign rd_cat[1] = cat_of(opa);
    assign rd_cat[2] = cat_of(opb);
    assign rd_cat[3] = cat_of(opb);

    assign wr_a = a_we && writes_reg(opa);
    assign wr_b = b_we && writes_reg(opb);

    assign wr_en[0]   = go_a && wr_a;
    assign wr_en[1]   = go_b && wr_b;
    assign wr_reg[0]  = a_dst;
    assign wr_reg[1]  = b_dst;
    assign wr_wait[0] = wait_of(opa, a_near, a_len);
    assign wr_wait[1] = wait_of(opb, b_near, b_len);

    dic_scoreboard #(.NREG(NREG), .NRD(4), .NWR(2)) sb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_reg  (rd_reg),
        .rd_cat  (rd_cat),
        .rd_ok   (rd_ok),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_wait (wr_wait)
    );

    dic_pair_rules #(.RW(RW)) pr_i (
        .a_op       (opa),
        .b_op       (opb),
        .a_wr       (wr_a),
        .a_dst      (a_dst),
        .b_src0     (b_src0),
        .b_src1     (b_src1),
        .solo       (solo),
        .unit_clash (unit_clash),
        .raw        (raw)
    );

    always_comb begin
        logic locked, ibusy;
        locked = (st_q.lock != '0);
        ibusy  = (st_q.ibusy != '0);

        why_a = WHY_NONE;
        if (a_vld) begin
            if (locked)                           why_a = WHY_SLOT;
            else if (!(rd_ok[0] && rd_ok[1]))     why_a = WHY_DATA;
            else if (uses_int(opa) && ibusy)      why_a = WHY_UNIT;
        end
        go_a = a_vld && (why_a == WHY_NONE);

        why_b = WHY_NONE;
        if (b_vld) begin
            if (!go_a)                                why_b = WHY_ORDER;
            else if (solo)                            why_b = WHY_SLOT;
            else if (!(rd_ok[2] && rd_ok[3]) || raw)  why_b = WHY_DATA;
            else if (unit_clash || (uses_int(opb) && ibusy)) why_b = WHY_UNIT;
        end
        go_b = b_vld && (why_b == WHY_NONE);

        st_d.lock  = locked ? st_q.lock - 1'b1 : '0;
        st_d.ibusy = ibusy ? st_q.ibusy - 1'b1 : '0;
        if (go_a && (opa == OP_CALL)) st_d.lock = LKW'(CALL_CYC - 1);
        if (go_a && uses_int(opa))    st_d.ibusy = hold_m1(opa, a_len);
        if (go_b && uses_int(opb))    st_d.ibusy = hold_m1(opb, b_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_cnt = {1'b0, go_a} + {1'b0, go_b};
    assign a_stall   = a_vld && !go_a;
    assign b_stall   = b_vld && !go_b;
    assign a_why     = why_a;
    assign b_why     = why_b;

endmodule

// File: rtl/dic_chk.sv
module dic_chk
    import dic_pkg::*;
#(
    parameter int RW       = 6,
    parameter int CALL_CYC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_vld,
    input logic [2:0]    a_op,
    input logic          a_we,
    input logic [RW-1:0] a_dst,
    input logic          b_vld,
    input logic [2:0]    b_op,
    input logic [RW-1:0] b_src0,
    input logic [RW-1:0] b_src1,
    input logic [1:0]    issue_cnt,
    input logic          a_stall,
    input logic          b_stall,
    input logic [2:0]    a_why,
    input logic [2:0]    b_why
);

    localparam int CW = $clog2(CALL_CYC) + 1;
    logic [CW-1:0] win_q;
    logic a_go, b_go;

    assign a_go = a_vld && !a_stall;
    assign b_go = b_vld && !b_stall;

    always_ff @(posedge clk) begin
        if (!rst_n)                                win_q <= '0;
        else if (a_go && (op_e'(a_op) == OP_CALL)) win_q <= CW'(CALL_CYC - 1);
        else if (win_q != '0)                      win_q <= win_q - 1'b1;
    end

    // R1
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt == ({1'b0, a_go} + {1'b0, b_go}));

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_go |-> a_go);

    // R3
    solo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> (!is_solo(op_e'(a_op)) && !is_solo(op_e'(b_op))));

    // R4
    call_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0) |-> (issue_cnt == 2'd0));

    // R5
    int_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> !(uses_int(op_e'(a_op)) && uses_int(op_e'(b_op))));

    // R6
    flt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> !((op_e'(a_op) == OP_FLOAT) && (op_e'(b_op) == OP_FLOAT)));

    // R10
    same_cycle_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_cnt == 2'd2) && a_we && writes_reg(op_e'(a_op)))
            |-> ((b_src0 != a_dst) && (b_src1 != a_dst)));

    // R12
    why_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_why == 3'd0) == !a_stall) && ((b_why == 3'd0) == !b_stall));

endmodule

bind dual_issue_ctrl dic_chk #(.RW(RW), .CALL_CYC(CALL_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_vld     (a_vld),
    .a_op      (a_op),
    .a_we      (a_we),
    .a_dst     (a_dst),
    .b_vld     (b_vld),
    .b_op      (b_op),
    .b_src0    (b_src0),
    .b_src1    (b_src1),
    .issue_cnt (issue_cnt),
    .a_stall   (a_stall),
    .b_stall   (b_stall),
    .a_why     (a_why),
    .b_why     (b_why)
);

// File: tb/dual_issue_ctrl_tb_top.sv
module dual_issue_ctrl_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_vld = 0, a_near = 0, a_we = 0;
    logic [2:0] a_op = 0, a_len = 0;
    logic [5:0] a_dst = 0, a_src0 = 0, a_src1 = 0;
    logic       b_vld = 0, b_near = 0, b_we = 0;
    logic [2:0] b_op = 0, b_len = 0;
    logic [5:0] b_dst = 0, b_src0 = 0, b_src1 = 0;
    logic [1:0] issue_cnt;
    logic       a_stall, b_stall;
    logic [2:0] a_why, b_why;

    always #(CLK_P/2) clk = ~clk;

    dual_issue_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_op(a_op), .a_near(a_near), .a_len(a_len), .a_we(a_we),
        .a_dst(a_dst), .a_src0(a_src0), .a_src1(a_src1),
        .b_vld(b_vld), .b_op(b_op), .b_near(b_near), .b_len(b_len), .b_we(b_we),
        .b_dst(b_dst), .b_src0(b_src0), .b_src1(b_src1),
        .issue_cnt(issue_cnt), .a_stall(a_stall), .b_stall(b_stall),
        .a_why(a_why), .b_why(b_why)
    );

    typedef struct {
        bit v; int op; bit n; int len; bit we; int d; int s0; int s1;
    } cand_t;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    cand_t ca, cb;

    // reference state: absolute cycle numbers
    int rdy [64][3];
    int ifree = 0;
    int lockend = 0;
    int cyc = 0;

    function automatic cand_t mk(int op, int len, bit n, bit we, int d, int s0, int s1);
        cand_t c;
        c.v = 1; c.op = op; c.len = len; c.n = n; c.we = we; c.d = d; c.s0 = s0; c.s1 = s1;
        return c;
    endfunction

    function automatic cand_t idle();
        cand_t c;
        c = mk(0, 1, 0, 0, 0, 0, 0);
        c.v = 0;
        return c;
    endfunction

    function automatic int cat(int op);
        if (op == 3) return 0;
        if (op == 2) return 1;
        return 2;
    endfunction

    function automatic bit intish(int op);
        return op == 0 || op == 1 || op == 2 || op == 7;
    endfunction

    function automatic bit solo(int op);
        return op == 4 || op == 5 || op == 6;
    endfunction

    function automatic bit wr(cand_t c);
        return c.we && (c.op == 0 || c.op == 1 || c.op == 3 || c.op == 7);
    endfunction

    function automatic int lat(cand_t c, int k);
        if (c.op == 0 || c.op == 7) begin
            if (c.len >= 3) return 4;
            if (c.len == 2) return 2;
            return (k == 0) ? 2 : 1;
        end
        if (c.op == 1) return (k == 0) ? 3 : 2;
        if (c.n) return (k == 1) ? 4 : 5;
        return (k == 1) ? 2 : 3;
    endfunction

    function automatic int hold(cand_t c);
        if (c.op == 0 || c.op == 7) begin
            if (c.len >= 3) return 4;
            if (c.len == 2) return 2;
        end
        return 1;
    endfunction

    function automatic bit srcok(cand_t c);
        return rdy[c.s0][cat(c.op)] <= cyc && rdy[c.s1][cat(c.op)] <= cyc;
    endfunction

    task automatic apply_issue(cand_t c);
        if (wr(c)) begin
            for (int k = 0; k < 3; k++) rdy[c.d][k] = cyc + lat(c, k);
        end
        if (intish(c.op)) ifree = cyc + hold(c);
        if (c.op == 6) lockend = cyc + 8;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(string tag);
        int wa, wb;
        bit ga, gb;
        @(negedge clk);
        a_vld = ca.v; a_op = 3'(ca.op); a_near = ca.n; a_len = 3'(ca.len); a_we = ca.we;
        a_dst = 6'(ca.d); a_src0 = 6'(ca.s0); a_src1 = 6'(ca.s1);
        b_vld = cb.v; b_op = 3'(cb.op); b_near = cb.n; b_len = 3'(cb.len); b_we = cb.we;
        b_dst = 6'(cb.d); b_src0 = 6'(cb.s0); b_src1 = 6'(cb.s1);
        #1;
        wa = 0; wb = 0; ga = 0; gb = 0;
        if (ca.v) begin
            if (cyc < lockend)                      wa = 3;
            else if (!srcok(ca))                    wa = 1;
            else if (intish(ca.op) && ifree > cyc)  wa = 2;
            ga = (wa == 0);
        end
        if (cb.v) begin
            if (!ga)                                 wb = 4;
            else if (solo(ca.op) || solo(cb.op))     wb = 3;
            else if (!srcok(cb) || (wr(ca) && (cb.s0 == ca.d || cb.s1 == ca.d))) wb = 1;
            else if (intish(cb.op) && (intish(ca.op) || ifree > cyc)) wb = 2;
            else if (ca.op == 3 && cb.op == 3)       wb = 2;
            gb = (wb == 0);
        end
        chk(tag, "issue_cnt", int'(issue_cnt), int'(ga) + int'(gb));
        chk(tag, "a_stall", int'(a_stall), int'(ca.v && !ga));
        chk(tag, "b_stall", int'(b_stall), int'(cb.v && !gb));
        chk(tag, "a_why", int'(a_why), wa);
        chk(tag, "b_why", int'(b_why), wb);
        if (ga) apply_issue(ca);
        if (gb) apply_issue(cb);
        cyc++;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < 64; r++) for (int k = 0; k < 3; k++) rdy[r][k] = 0;
        ca = idle(); cb = idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state and register 0 immediately readable
        step("R11");
        ca = mk(0, 1, 0, 1, 0, 0, 0); cb = mk(3, 1, 0, 1, 9, 0, 0);
        step("R11");
        ca = idle(); cb = idle(); step("R11");

        // R7: single-word integer forwarding vs float consumer
        ca = mk(0, 1, 0, 1, 1, 2, 2); step("R7");
        ca = mk(3, 1, 0, 1, 8, 1, 1); step("R7"); step("R7");
        ca = mk(0, 1, 0, 1, 1, 2, 2); step("R7");
        ca = mk(0, 1, 0, 1, 10, 1, 1); step("R7");
        // R7/R5: two-word and long forms
        ca = mk(0, 2, 0, 1, 2, 0, 0); step("R7");
        ca = mk(1, 1, 0, 1, 11, 2, 2); repeat (2) step("R7");
        ca = mk(0, 5, 0, 1, 3, 0, 0); step("R7");
        ca = mk(2, 1, 0, 0, 0, 3, 3); repeat (5) step("R7");
        ca = mk(0, 6, 0, 1, 12, 0, 0); cb = mk(3, 1, 0, 1, 13, 0, 0); step("R5");
        ca = mk(3, 1, 0, 1, 14, 0, 0); cb = mk(2, 1, 0, 0, 0, 0, 0); repeat (4) step("R5");
        cb = idle();

        // R8: load latencies
        ca = mk(1, 1, 0, 1, 4, 0, 0); step("R8");
        ca = mk(0, 1, 0, 1, 15, 4, 0); cb = mk(3, 1, 0, 1, 16, 4, 4); repeat (3) step("R8");
        cb = idle();

        // R9: float trunc and nearest, store shortcut
        ca = mk(3, 1, 0, 1, 5, 0, 0); step("R9");
        ca = mk(2, 1, 0, 0, 0, 5, 5); repeat (2) step("R9");
        ca = mk(3, 1, 1, 1, 6, 0, 0); step("R9");
        ca = mk(2, 1, 0, 0, 0, 6, 6); repeat (4) step("R9");
        ca = mk(3, 1, 1, 1, 6, 0, 0); step("R9");
        ca = mk(0, 1, 0, 1, 17, 6, 6); repeat (5) step("R9");

        // R6: float pairing
        ca = mk(3, 1, 0, 1, 20, 0, 0); cb = mk(3, 1, 0, 1, 21, 0, 0); step("R6");
        ca = mk(3, 1, 0, 1, 20, 0, 0); cb = mk(0, 1, 0, 1, 22, 0, 0); step("R6");

        // R5: integer-unit pairing
        ca = mk(1, 1, 0, 1, 23, 0, 0); cb = mk(2, 1, 0, 0, 0, 0, 0); step("R5");
        ca = mk(7, 1, 0, 1, 24, 0, 0); cb = mk(0, 1, 0, 1, 25, 0, 0); step("R5");

        // R3: solo classes
        ca = mk(4, 1, 0, 1, 26, 0, 0); cb = mk(0, 1, 0, 1, 27, 0, 0); step("R3");
        ca = mk(0, 1, 0, 1, 28, 0, 0); cb = mk(5, 1, 0, 0, 0, 0, 0); step("R3");

        // R12: write flag ignored for non-writing classes
        ca = mk(4, 1, 0, 1, 30, 0, 0); cb = idle(); step("R12");
        ca = mk(3, 1, 0, 1, 31, 30, 30); step("R12");

        // R10: same-cycle dependency
        ca = mk(0, 1, 0, 1, 7, 0, 0); cb = mk(3, 1, 0, 1, 32, 0, 7); step("R10");
        ca = mk(2, 1, 0, 1, 7, 0, 0); cb = mk(3, 1, 0, 1, 32, 7, 0); step("R10");

        // R2: older stalled on data, younger independent
        ca = mk(1, 1, 0, 1, 33, 0, 0); cb = idle(); step("R2");
        ca = mk(0, 1, 0, 1, 34, 33, 0); cb = mk(3, 1, 0, 1, 35, 0, 0); step("R2");
        ca = idle(); cb = mk(0, 1, 0, 1, 36, 0, 0); step("R2");

        // R4/R12: call window, slot beats data for A
        ca = mk(1, 1, 0, 1, 37, 0, 0); cb = idle(); step("R4");
        ca = mk(6, 1, 0, 0, 0, 0, 0); cb = mk(0, 1, 0, 1, 38, 0, 0); step("R4");
        ca = mk(3, 1, 0, 1, 39, 37, 37); cb = mk(0, 1, 0, 1, 40, 0, 0); repeat (8) step("R4");
        ca = mk(6, 1, 0, 0, 0, 0, 0); cb = idle(); step("R4");
        ca = mk(0, 1, 0, 1, 41, 0, 0); repeat (8) step("R4");

        // R1: random mix over a small register set
        for (int i = 0; i < 2500; i++) begin
            ca = mk($urandom_range(7), $urandom_range(7), 1'($urandom_range(1)), 1'($urandom_range(1)),
                    $urandom_range(7), $urandom_range(7), $urandom_range(7));
            cb = mk($urandom_range(7), $urandom_range(7), 1'($urandom_range(1)), 1'($urandom_range(1)),
                    $urandom_range(7), $urandom_range(7), $urandom_range(7));
            if ($urandom_range(9) == 0) ca.v = 0;
            if ($urandom_range(9) == 0) cb.v = 0;
            if ((ca.op == 6 || cb.op == 6) && $urandom_range(3) != 0) begin
                ca.op = 0; cb.op = 1;
            end
            step("R1");
        end

        done = 1;
        finish_run();
    end

endmodule